// File: doc/BRIEF.md
# Branch target PC writer

This block decides the next program counter and the active instruction set whenever software writes the PC. The write can come from four sources: a register-exchange branch, a plain branch, an ALU result written to the PC, or a value loaded into the PC. Bit 0 of the target selects the instruction set on exchange-style writes. A configuration input decides whether a word-unaligned target in the 32-bit set is realigned or kept and flagged. The block computes the new PC, the new set and an alignment-fault flag. These appear on registered outputs one cycle after the request strobe.

A separate exception-return strobe is checked against the current exception level and processor mode. The block reports on its own registered outputs whether the return is undefined, unpredictable or allowed. Both strobes may be raised in the same cycle. A small state machine tracks which results are due. The state is ST_IDLE when nothing is due, ST_PC when only a PC result is due, ST_RET when only a return verdict is due, and ST_BOTH when both are due. On every clock edge the next state is picked from the pair (request strobe, return strobe). That pair takes the machine from any state to ST_IDLE, ST_PC, ST_RET or ST_BOTH, and a state lasts exactly one cycle unless the same pair repeats.

Top module: `pcw_top`

## Requirements
- R1: While reset is asserted, and after reset until the first request, `out_valid`, `ret_valid`, `ret_undef`, `ret_unpred`, `align_fault` and `next_iset` are 0 and `next_pc` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `req_valid`=1, and 0 otherwise. `ret_valid` behaves the same way with respect to `eret_req`.
- R3: Exchange write (`wr_kind`=2'b00) with target bit 0 = 1 selects the compressed set (`next_iset`=1) and gives the target with bit 0 cleared, with no fault.
- R4: Exchange write with target bits 1:0 = 2'b00 selects the 32-bit set (`next_iset`=0) and gives the target unchanged, with no fault.
- R5: Exchange write with target bits 1:0 = 2'b10 and `force_align`=1 selects the 32-bit set, clears bit 1 and raises no fault.
- R6: Exchange write with target bits 1:0 = 2'b10 and `force_align`=0 selects the 32-bit set, keeps the target unchanged and sets `align_fault`=1.
- R7: Plain branch write (`wr_kind`=2'b01) keeps `next_iset` equal to `cur_iset` and never faults. It clears bits 1:0 when `cur_iset`=0 (32-bit set) and only bit 0 when `cur_iset`=1 (compressed set).
- R8: ALU write (`wr_kind`=2'b10) follows the exchange rules (R3 to R6) when `cur_iset`=0 and the plain-branch rules (R7) when `cur_iset`=1.
- R9: Load write (`wr_kind`=2'b11) follows the exchange rules in either current set.
- R10: An exception-return request at `cur_level`=2'b10 (hypervisor) gives `ret_undef`=1 and `ret_unpred`=0, whatever the mode.
- R11: At other levels, a return request with `cur_mode` 5'b10000 (user) or 5'b11111 (system) gives `ret_unpred`=1 and `ret_undef`=0. Any other mode gives both flags 0.
- R12: A PC write and a return request in the same cycle are both reported in the next cycle, each with the result it would have alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | PC write request strobe |
| wr_kind | input | 2 | Write kind: 00 exchange, 01 branch, 10 ALU, 11 load |
| target | input | ADDR_W | Target address |
| cur_iset | input | 1 | Current set: 0 = 32-bit, 1 = compressed |
| force_align | input | 1 | Realign unaligned 32-bit-set exchange targets |
| eret_req | input | 1 | Exception-return check strobe |
| cur_level | input | 2 | Current exception level, 2'b10 = hypervisor |
| cur_mode | input | 5 | Current processor mode code |
| out_valid | output | 1 | PC result valid |
| next_pc | output | ADDR_W | New program counter |
| next_iset | output | 1 | New instruction set |
| align_fault | output | 1 | Target kept unaligned in 32-bit set |
| ret_valid | output | 1 | Return verdict valid |
| ret_undef | output | 1 | Return is undefined |
| ret_unpred | output | 1 | Return is unpredictable |

## Verification
The PC-write path and the exception-return check can fall in the same cycle, which moves the machine into ST_BOTH. The bench provokes this by raising `req_valid` and `eret_req` on the same clock edge. It uses both an allowed return and a faulting exchange, and it also issues back-to-back combined requests. Each path has its own scoreboard queue whose items carry the cycle in which they are due. A result is judged correct only if both valid strobes rise in that cycle and each carries the value it would carry alone.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    typedef enum logic [1:0] {
        WK_EXCH   = 2'b00,
        WK_BRANCH = 2'b01,
        WK_ALU    = 2'b10,
        WK_LOAD   = 2'b11
    } wr_kind_e;

    localparam logic ISET_WIDE = 1'b0;
    localparam logic ISET_COMP = 1'b1;

    localparam int LVL_W  = 2;
    localparam int MODE_W = 5;

    localparam logic [LVL_W-1:0]  LVL_HYP   = 2'b10;
    localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_SYS  = 5'b11111;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PC   = 2'b01,
        ST_RET  = 2'b10,
        ST_BOTH = 2'b11
    } pcw_state_e;

endpackage

// File: rtl/pcw_target_calc.sv
module pcw_target_calc
    import pcw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] tgt,
    input  logic              iset_in,
    input  logic              force_align,
    output logic [ADDR_W-1:0] pc_out,
    output logic              iset_out,
    output logic              fault
);

    logic use_exchange;

    always_comb begin
        unique case (wr_kind_e'(kind))
            WK_EXCH:   use_exchange = 1'b1;
            WK_BRANCH: use_exchange = 1'b0;
            WK_ALU:    use_exchange = (iset_in == ISET_WIDE);
            WK_LOAD:   use_exchange = 1'b1;
            default:   use_exchange = 1'b1;
        endcase
    end

    always_comb begin
        pc_out   = tgt;
        iset_out = iset_in;
        fault    = 1'b0;
        if (use_exchange) begin
            if (tgt[0]) begin
                iset_out  = ISET_COMP;
                pc_out[0] = 1'b0;
            end else begin
                iset_out = ISET_WIDE;
                if (tgt[1]) begin
                    if (force_align) pc_out[1] = 1'b0;
                    else             fault     = 1'b1;
                end
            end
        end else begin
            pc_out[0] = 1'b0;
            if (iset_in == ISET_WIDE) pc_out[1] = 1'b0;
        end
    end

endmodule

// File: rtl/pcw_eret_check.sv
module pcw_eret_check
    import pcw_pkg::*;
(
    input  logic [LVL_W-1:0]  level,
    input  logic [MODE_W-1:0] mode,
    output logic              undef,
    output logic              unpred
);

    always_comb begin
        undef  = 1'b0;
        unpred = 1'b0;
        if (level == LVL_HYP)
            undef = 1'b1;
        else if (mode == MODE_USER || mode == MODE_SYS)
            unpred = 1'b1;
    end

endmodule

// File: rtl/pcw_top.sv
module pcw_top
    import pcw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        wr_kind,
    input  logic [ADDR_W-1:0] target,
    input  logic              cur_iset,
    input  logic              force_align,
    input  logic              eret_req,
    input  logic [1:0]        cur_level,
    input  logic [4:0]        cur_mode,
    output logic              out_valid,
    output logic [ADDR_W-1:0] next_pc,
    output logic              next_iset,
    output logic              align_fault,
    output logic              ret_valid,
    output logic              ret_undef,
    output logic              ret_unpred
);

    pcw_state_e        state_q, state_d;
    logic [ADDR_W-1:0] calc_pc;
    logic              calc_iset;
    logic              calc_fault;
    logic              chk_undef;
    logic              chk_unpred;

    pcw_target_calc #(.ADDR_W(ADDR_W)) u_calc (
        .kind        (wr_kind),
        .tgt         (target),
        .iset_in     (cur_iset),
        .force_align (force_align),
        .pc_out      (calc_pc),
        .iset_out    (calc_iset),
        .fault       (calc_fault)
    );

    pcw_eret_check u_eret (
        .level  (cur_level),
        .mode   (cur_mode),
        .undef  (chk_undef),
        .unpred (chk_unpred)
    );

    always_comb begin
        unique case ({req_valid, eret_req})
            2'b00:   state_d = ST_IDLE;
            2'b10:   state_d = ST_PC;
            2'b01:   state_d = ST_RET;
            2'b11:   state_d = ST_BOTH;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc     <= '0;
            next_iset   <= 1'b0;
            align_fault <= 1'b0;
            ret_undef   <= 1'b0;
            ret_unpred  <= 1'b0;
        end else begin
            if (req_valid) begin
                next_pc     <= calc_pc;
                next_iset   <= calc_iset;
                align_fault <= calc_fault;
            end
            if (eret_req) begin
                ret_undef  <= chk_undef;
                ret_unpred <= chk_unpred;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin out_valid = 1'b0; ret_valid = 1'b0; end
            ST_PC:   begin out_valid = 1'b1; ret_valid = 1'b0; end
            ST_RET:  begin out_valid = 1'b0; ret_valid = 1'b1; end
            ST_BOTH: begin out_valid = 1'b1; ret_valid = 1'b1; end
            default: begin out_valid = 1'b0; ret_valid = 1'b0; end
        endcase
    end

    // R2
    pc_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2
    pc_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R12
    ret_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eret_req |=> ret_valid);

    // R7
    branch_keeps_iset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && wr_kind == WK_BRANCH) |=> (next_iset == $past(cur_iset) && !align_fault));

    // R3
    pc_bit0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !next_pc[0]);

    // R6
    fault_only_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && align_fault) |-> (next_iset == ISET_WIDE && next_pc[1]));

    // R10
    ret_flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $countones({ret_undef, ret_unpred}) <= 1);

endmodule

// File: tb/tb_pcw_top.sv
module tb_pcw_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  wr_kind;
    logic [31:0] target;
    logic        cur_iset;
    logic        force_align;
    logic        eret_req;
    logic [1:0]  cur_level;
    logic [4:0]  cur_mode;
    logic        out_valid;
    logic [31:0] next_pc;
    logic        next_iset;
    logic        align_fault;
    logic        ret_valid;
    logic        ret_undef;
    logic        ret_unpred;

    always #5 clk = ~clk;

    pcw_top #(.ADDR_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wr_kind(wr_kind),
        .target(target), .cur_iset(cur_iset), .force_align(force_align),
        .eret_req(eret_req), .cur_level(cur_level), .cur_mode(cur_mode),
        .out_valid(out_valid), .next_pc(next_pc), .next_iset(next_iset),
        .align_fault(align_fault), .ret_valid(ret_valid),
        .ret_undef(ret_undef), .ret_unpred(ret_unpred)
    );

    typedef struct {
        int          due;
        logic [31:0] pc;
        logic        iset;
        logic        fault;
        string       rq;
    } pc_item_t;

    typedef struct {
        int    due;
        logic  undef;
        logic  unpred;
        string rq;
    } ret_item_t;

    pc_item_t  pc_q[$];
    ret_item_t ret_q[$];
    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic pc_item_t model_pc(input logic [1:0] k, input logic [31:0] t,
                                          input logic is, input logic fa);
        pc_item_t r;
        logic exch;
        exch = (k == 2'b00) || (k == 2'b11) || (k == 2'b10 && is == 1'b0);
        r.pc = t; r.iset = is; r.fault = 1'b0; r.due = 0; r.rq = "";
        if (exch) begin
            if (t[0]) begin r.iset = 1'b1; r.pc[0] = 1'b0; end
            else begin
                r.iset = 1'b0;
                if (t[1]) begin
                    if (fa) r.pc[1] = 1'b0; else r.fault = 1'b1;
                end
            end
        end else begin
            r.pc[0] = 1'b0;
            if (!is) r.pc[1] = 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        req_valid = 1'b0;
        eret_req  = 1'b0;
    endtask

    task automatic issue(input bit do_pc, input logic [1:0] k, input logic [31:0] t,
                         input logic is, input logic fa,
                         input bit do_ret, input logic [1:0] lvl, input logic [4:0] md,
                         input string rq);
        pc_item_t  p;
        ret_item_t e;
        @(negedge clk);
        req_valid = do_pc; wr_kind = k; target = t; cur_iset = is; force_align = fa;
        eret_req = do_ret; cur_level = lvl; cur_mode = md;
        if (do_pc) begin
            p = model_pc(k, t, is, fa);
            p.due = cyc + 1; p.rq = rq;
            pc_q.push_back(p);
        end
        if (do_ret) begin
            e.due = cyc + 1; e.rq = rq;
            e.undef  = (lvl == 2'b10);
            e.unpred = (lvl != 2'b10) && (md == 5'b10000 || md == 5'b11111);
            ret_q.push_back(e);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            if (pc_q.size() > 0 && pc_q[0].due == cyc) begin
                pc_item_t p;
                p = pc_q.pop_front();
                check(p.rq, {63'd0, out_valid}, 64'd1, "out_valid");
                check(p.rq, {32'd0, next_pc}, {32'd0, p.pc}, "next_pc");
                check(p.rq, {63'd0, next_iset}, {63'd0, p.iset}, "next_iset");
                check(p.rq, {63'd0, align_fault}, {63'd0, p.fault}, "align_fault");
            end else if (out_valid !== 1'b0) begin
                check("R2", {63'd0, out_valid}, 64'd0, "unexpected out_valid");
            end
            if (ret_q.size() > 0 && ret_q[0].due == cyc) begin
                ret_item_t e;
                e = ret_q.pop_front();
                check(e.rq, {63'd0, ret_valid}, 64'd1, "ret_valid");
                check(e.rq, {63'd0, ret_undef}, {63'd0, e.undef}, "ret_undef");
                check(e.rq, {63'd0, ret_unpred}, {63'd0, e.unpred}, "ret_unpred");
            end else if (ret_valid !== 1'b0) begin
                check("R2", {63'd0, ret_valid}, 64'd0, "unexpected ret_valid");
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; eret_req = 1'b0; wr_kind = 2'b00;
        target = '0; cur_iset = 1'b0; force_align = 1'b0; cur_level = 2'b00; cur_mode = 5'b10011;
        repeat (3) @(negedge clk);
        // R1: during reset
        check("R1", {63'd0, out_valid}, 64'd0, "out_valid in reset");
        check("R1", {63'd0, ret_valid}, 64'd0, "ret_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: after reset, before any request
        check("R1", {32'd0, next_pc}, 64'd0, "next_pc after reset");
        check("R1", {60'd0, next_iset, align_fault, ret_undef, ret_unpred}, 64'd0, "flags after reset");

        issue(1, 2'b00, 32'h1000_0001, 1'b0, 1'b0, 0, 2'b00, 5'b10011, "R3");
        quiet();
        issue(1, 2'b00, 32'h2000_0004, 1'b1, 1'b0, 0, 2'b00, 5'b10011, "R4");
        issue(1, 2'b00, 32'h2000_0006, 1'b0, 1'b1, 0, 2'b00, 5'b10011, "R5");
        issue(1, 2'b00, 32'h2000_0006, 1'b1, 1'b0, 0, 2'b00, 5'b10011, "R6");
        quiet();
        issue(1, 2'b01, 32'h3000_0007, 1'b0, 1'b0, 0, 2'b00, 5'b10011, "R7");
        issue(1, 2'b01, 32'h3000_0007, 1'b1, 1'b0, 0, 2'b00, 5'b10011, "R7");
        issue(1, 2'b01, 32'h3000_0006, 1'b1, 1'b0, 0, 2'b00, 5'b10011, "R7");
        quiet();
        issue(1, 2'b10, 32'h4000_0003, 1'b0, 1'b0, 0, 2'b00, 5'b10011, "R8");
        issue(1, 2'b10, 32'h4000_0002, 1'b1, 1'b0, 0, 2'b00, 5'b10011, "R8");
        issue(1, 2'b10, 32'h4000_0006, 1'b0, 1'b0, 0, 2'b00, 5'b10011, "R8");
        issue(1, 2'b10, 32'h4000_0007, 1'b1, 1'b1, 0, 2'b00, 5'b10011, "R8");
        quiet();
        issue(1, 2'b11, 32'h5000_0006, 1'b1, 1'b0, 0, 2'b00, 5'b10011, "R9");
        issue(1, 2'b11, 32'h5000_0009, 1'b0, 1'b0, 0, 2'b00, 5'b10011, "R9");
        issue(1, 2'b11, 32'h5000_000E, 1'b1, 1'b1, 0, 2'b00, 5'b10011, "R9");
        quiet();
        issue(0, 2'b00, 32'h0, 1'b0, 1'b0, 1, 2'b10, 5'b11010, "R10");
        issue(0, 2'b00, 32'h0, 1'b0, 1'b0, 1, 2'b10, 5'b10000, "R10");
        quiet();
        issue(0, 2'b00, 32'h0, 1'b0, 1'b0, 1, 2'b01, 5'b10000, "R11");
        issue(0, 2'b00, 32'h0, 1'b0, 1'b0, 1, 2'b00, 5'b11111, "R11");
        issue(0, 2'b00, 32'h0, 1'b0, 1'b0, 1, 2'b01, 5'b10011, "R11");
        quiet();
        issue(1, 2'b00, 32'h6000_0002, 1'b0, 1'b0, 1, 2'b01, 5'b10111, "R12");
        issue(1, 2'b01, 32'h6000_0013, 1'b1, 1'b0, 1, 2'b10, 5'b10011, "R12");
        issue(1, 2'b11, 32'h6000_0021, 1'b0, 1'b0, 1, 2'b00, 5'b11111, "R12");
        quiet();
        repeat (3) quiet();
        check("R2", {32'd0, 32'(pc_q.size() + ret_q.size())}, 64'd0, "pending results");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule